// File: doc/BRIEF.md
# Half-Duplex Modem Control Sequencer

This block is the digital control section of a half-duplex FSK modem. It sits between the terminal-side handshake lines and the analog modulator and demodulator. When the terminal asks to send, it turns on the transmit carrier and grants clear-to-send after a guard delay. It turns a raw, fast carrier-detect flag into a qualified carrier-detect line. Received data is held at mark whenever it cannot be trusted: with no carrier, while the local transmitter is on over a two-wire line, and during a squelch window after the transmitter stops.

All delays are counted in ticks of a slow timing clock, which is divided down from the master clock. The same slow clock is also driven out on a pin for use by off-chip delay circuits. A two-bit delay mode chooses between two internal clear-to-send delays or hands both the clear-to-send and carrier-detect timing to external logic. A loopback mode reroutes the data and handshake paths for testing. A separate answer-tone request is honoured only while the transmitter is requested.

Top module: `hdx_modem_ctrl`

## Requirements
- R1: `timing_clk` is a square wave with a period of 2^DIV_LOG2 clocks and equal high and low halves. A tick is the clock edge at which it falls. After reset is released, the first tick is the 2^DIV_LOG2-th edge.
- R2: With `dly_mode` 0 (long delay, LONG_T ticks) or 1 (short delay, SHORT_T ticks) and `loop_test` low, `cts_n` goes low at the tick edge on which the count of ticks sampled with `rts_n` low reaches the selected delay. `cts_n` is high in the same cycle that `rts_n` is high, and any clock edge that samples `rts_n` high restarts the count.
- R3: With `dly_mode[1]` high (external mode) and `loop_test` low, `cts_n` equals `ext_rts_n` and `cd_n` equals `cd_ext_n` in the same cycle.
- R4: In internal modes, `cd_n` goes low after CD_ON consecutive ticks that sample `cd_fast_n` low. It goes high after CD_OFF consecutive ticks that sample `cd_fast_n` high. A tick that samples the current state restarts the run, and samples between ticks are ignored.
- R5: With `sq_off` low, a clock edge that samples `rts_n` rising starts a squelch that lasts the next SQ_T ticks. While `sq_off` is high, no squelch is active.
- R6: With `loop_test` low, `rx_data` is 1 (mark) when `cd_n` is high, or when `sq_off` is low and `rts_n` is low, or while the squelch is active. Otherwise `rx_data` equals `rx_demod`.
- R7: With `loop_test` high: `rx_data` equals `tx_data`, `cts_n` equals `rts_n`, `tx_carrier_en` equals `carrier_ctl`, and the modulator data comes from `rx_demod`.
- R8: With `loop_test` low, `tx_carrier_en` is the inverse of `rts_n`. `tx_mod_data` equals the selected data while the carrier is enabled and is 1 (mark) when it is not.
- R9: `tone_on` is high exactly when both `tone_en_n` and `rts_n` are low.
- R10: During reset, `timing_clk` is low, `cts_n` is high and `cd_n` is high in internal modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rts_n | input | 1 | Request to send, low = on |
| tx_data | input | 1 | Terminal data to transmit |
| cd_fast_n | input | 1 | Raw carrier flag from the demodulator, low = carrier |
| rx_demod | input | 1 | Demodulated receive data |
| sq_off | input | 1 | High for four-wire use: squelch and transmit-side forcing off |
| loop_test | input | 1 | Digital loopback enable |
| carrier_ctl | input | 1 | Carrier enable used during loopback |
| dly_mode | input | 2 | 0 long delay, 1 short delay, 2 or 3 external delays |
| ext_rts_n | input | 1 | Delayed request from external logic |
| cd_ext_n | input | 1 | Carrier detect from external delay logic |
| tone_en_n | input | 1 | Answer-tone request, low = on |
| cts_n | output | 1 | Clear to send, low = on |
| cd_n | output | 1 | Qualified carrier detect, low = on |
| rx_data | output | 1 | Receive data to the terminal |
| tx_carrier_en | output | 1 | Transmit carrier enable |
| tx_mod_data | output | 1 | Data fed to the modulator |
| tone_on | output | 1 | Answer-tone enable |
| timing_clk | output | 1 | Divided timing clock |

## Verification
Every result depends on how many ticks have been seen. Clear-to-send and qualified carrier change in the cycle right after the tick edge that completes their count. The squelch starts after the edge that samples the rising request, and ends after its SQ_T-th later tick. The loopback, external, answer-tone and modulator paths respond in the same cycle as their inputs. The bench keeps a tick-counting reference of its own, clocked on the same edge as the design. It changes inputs shortly after the rising edge and compares every output on the falling edge, so each expected value already includes the one register stage.

// File: rtl/hdx_pkg.sv
package hdx_pkg;

  // dly_mode[1] hands both delays to external logic
  function automatic logic is_external(logic [1:0] mode);
    return mode[1];
  endfunction

  // RS-to-CS delay in ticks selected by dly_mode[0]
  function automatic int rscs_limit(logic [1:0] mode, int long_t, int short_t);
    return mode[0] ? short_t : long_t;
  endfunction

  // consecutive ticks needed to leave the current carrier state
  function automatic int cd_need(logic cur_on, int on_t, int off_t);
    return cur_on ? off_t : on_t;
  endfunction

  // receive data untrustworthy
  function automatic logic rx_mark_forced(logic cd_off, logic tx_on_2w, logic squelching);
    return cd_off | tx_on_2w | squelching;
  endfunction

endpackage

// File: rtl/hdx_tick_gen.sv
module hdx_tick_gen #(
  parameter int DIV_LOG2 = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick,
  output logic timing_clk
);
  logic [DIV_LOG2-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  assign tick       = &div_q;
  assign timing_clk = div_q[DIV_LOG2-1];

  AST_TICK_DROPS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !timing_clk);  // R1
  AST_FALL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(timing_clk) |-> $past(tick));  // R1
endmodule

// File: rtl/hdx_rscs_timer.sv
module hdx_rscs_timer
  import hdx_pkg::*;
#(
  parameter int LONG_T  = 182,
  parameter int SHORT_T = 22
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rts_n,
  input  logic [1:0] mode,
  output logic       cts_on
);
  localparam int MAXT = (LONG_T > SHORT_T) ? LONG_T : SHORT_T;
  localparam int W    = $clog2(MAXT + 1);

  logic [W-1:0] seen_q;
  int           limit;

  assign limit = rscs_limit(mode, LONG_T, SHORT_T);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      cts_on <= 1'b0;
    end else if (rts_n) begin
      seen_q <= '0;
      cts_on <= 1'b0;
    end else if (tick && !cts_on) begin
      seen_q <= seen_q + 1'b1;
      if (int'(seen_q) + 1 >= limit) cts_on <= 1'b1;
    end
  end

  AST_RTS_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rts_n |=> !cts_on);  // R2
  AST_GRANT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cts_on) |-> ($past(tick) && !$past(rts_n)));  // R2
endmodule

// File: rtl/hdx_cd_qualifier.sv
module hdx_cd_qualifier
  import hdx_pkg::*;
#(
  parameter int ON_T  = 9,
  parameter int OFF_T = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cd_fast_n,
  output logic cd_on
);
  localparam int MAXT = (ON_T > OFF_T) ? ON_T : OFF_T;
  localparam int W    = $clog2(MAXT + 1);

  logic [W-1:0] run_q;
  logic         want_on;

  assign want_on = !cd_fast_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      cd_on <= 1'b0;
    end else if (tick) begin
      if (want_on == cd_on) begin
        run_q <= '0;
      end else if (int'(run_q) + 1 >= cd_need(cd_on, ON_T, OFF_T)) begin
        cd_on <= want_on;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  AST_CD_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cd_on) |-> $past(tick));  // R4
  AST_CD_FOLLOWS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cd_on) |-> (cd_on == !$past(cd_fast_n)));  // R4
endmodule

// File: rtl/hdx_squelch.sv
module hdx_squelch #(
  parameter int SQ_T = 131
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rts_n,
  input  logic sq_off,
  output logic active
);
  localparam int W = $clog2(SQ_T + 1);

  logic [W-1:0] left_q;
  logic         rts_q;
  logic         rts_rise;

  assign rts_rise = rts_n && !rts_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rts_q  <= 1'b1;
      left_q <= '0;
    end else begin
      rts_q <= rts_n;
      if (sq_off)                     left_q <= '0;
      else if (rts_rise)              left_q <= W'(SQ_T);
      else if (tick && left_q != '0)  left_q <= left_q - 1'b1;
    end
  end

  assign active = (left_q != '0);

  AST_SQUELCH_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_rise && !sq_off) |=> active);  // R5
  AST_SQUELCH_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    sq_off |=> !active);  // R5
endmodule

// File: rtl/hdx_modem_ctrl.sv
module hdx_modem_ctrl
  import hdx_pkg::*;
#(
  parameter int DIV_LOG2 = 12,
  parameter int LONG_T   = 182,
  parameter int SHORT_T  = 22,
  parameter int CD_ON_T  = 9,
  parameter int CD_OFF_T = 9,
  parameter int SQ_T     = 131
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rts_n,
  input  logic       tx_data,
  input  logic       cd_fast_n,
  input  logic       rx_demod,
  input  logic       sq_off,
  input  logic       loop_test,
  input  logic       carrier_ctl,
  input  logic [1:0] dly_mode,
  input  logic       ext_rts_n,
  input  logic       cd_ext_n,
  input  logic       tone_en_n,
  output logic       cts_n,
  output logic       cd_n,
  output logic       rx_data,
  output logic       tx_carrier_en,
  output logic       tx_mod_data,
  output logic       tone_on,
  output logic       timing_clk
);
  logic tick;
  logic cts_on;
  logic cd_on;
  logic squelching;
  logic ext_mode;
  logic rx_forced;
  logic mod_src;

  hdx_tick_gen #(.DIV_LOG2(DIV_LOG2)) i_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick), .timing_clk(timing_clk));

  hdx_rscs_timer #(.LONG_T(LONG_T), .SHORT_T(SHORT_T)) i_rscs (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rts_n(rts_n),
    .mode(dly_mode), .cts_on(cts_on));

  hdx_cd_qualifier #(.ON_T(CD_ON_T), .OFF_T(CD_OFF_T)) i_cdq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cd_fast_n(cd_fast_n), .cd_on(cd_on));

  hdx_squelch #(.SQ_T(SQ_T)) i_sq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rts_n(rts_n),
    .sq_off(sq_off), .active(squelching));

  assign ext_mode = is_external(dly_mode);

  always_comb begin
    if (loop_test)     cts_n = rts_n;
    else if (ext_mode) cts_n = ext_rts_n;
    else               cts_n = rts_n | !cts_on;
  end

  assign cd_n      = ext_mode ? cd_ext_n : !cd_on;
  assign rx_forced = rx_mark_forced(cd_n, !sq_off && !rts_n, squelching);
  assign rx_data   = loop_test ? tx_data : (rx_forced | rx_demod);

  assign tx_carrier_en = loop_test ? carrier_ctl : !rts_n;
  assign mod_src       = loop_test ? rx_demod : tx_data;
  assign tx_mod_data   = tx_carrier_en ? mod_src : 1'b1;
  assign tone_on       = !tone_en_n && !rts_n;

  AST_NO_CARRIER_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_test && cd_n) |-> rx_data);  // R6
  AST_SQUELCH_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_test && squelching) |-> rx_data);  // R6
  AST_IDLE_MOD_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_carrier_en |-> tx_mod_data);  // R8
  AST_TONE_NEEDS_RTS: assert property (@(posedge clk) disable iff (!rst_n)
    tone_on |-> !rts_n);  // R9
  AST_CTS_NEEDS_RTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_test && !ext_mode && !cts_n) |-> !rts_n);  // R2
endmodule

// File: tb/test_hdx_modem_ctrl.sv
`timescale 1ns/1ps
module test_hdx_modem_ctrl;
  localparam int DIVL  = 3;
  localparam int PER   = 1 << DIVL;
  localparam int LNG   = 6;
  localparam int SHT   = 2;
  localparam int CDON  = 3;
  localparam int CDOFF = 2;
  localparam int SQT   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rts_n = 1'b1, tx_data = 1'b1, cd_fast_n = 1'b1, rx_demod = 1'b1;
  logic sq_off = 1'b0, loop_test = 1'b0, carrier_ctl = 1'b0;
  logic [1:0] dly_mode = 2'd0;
  logic ext_rts_n = 1'b1, cd_ext_n = 1'b1, tone_en_n = 1'b1;
  logic cts_n, cd_n, rx_data, tx_carrier_en, tx_mod_data, tone_on, timing_clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit cmp_on = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  hdx_modem_ctrl #(.DIV_LOG2(DIVL), .LONG_T(LNG), .SHORT_T(SHT),
                   .CD_ON_T(CDON), .CD_OFF_T(CDOFF), .SQ_T(SQT)) i_hdx_modem_ctrl (
    .clk(clk), .rst_n(rst_n), .rts_n(rts_n), .tx_data(tx_data),
    .cd_fast_n(cd_fast_n), .rx_demod(rx_demod), .sq_off(sq_off),
    .loop_test(loop_test), .carrier_ctl(carrier_ctl), .dly_mode(dly_mode),
    .ext_rts_n(ext_rts_n), .cd_ext_n(cd_ext_n), .tone_en_n(tone_en_n),
    .cts_n(cts_n), .cd_n(cd_n), .rx_data(rx_data), .tx_carrier_en(tx_carrier_en),
    .tx_mod_data(tx_mod_data), .tone_on(tone_on), .timing_clk(timing_clk));

  task automatic chk(string req, string what, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference: tick counting from the requirements
  int unsigned cyc;
  int granted_ticks, cd_run, sq_left;
  bit ref_cts, ref_cd, prev_rts;

  function automatic int delay_of(logic [1:0] m);
    return m[0] ? SHT : LNG;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0; granted_ticks = 0; ref_cts = 0; ref_cd = 0;
      cd_run = 0; sq_left = 0; prev_rts = 1;
    end else begin
      bit at_tick;
      at_tick = (cyc % PER) == PER - 1;
      if (rts_n) begin
        granted_ticks = 0; ref_cts = 0;
      end else if (at_tick && !ref_cts) begin
        granted_ticks++;
        if (granted_ticks >= delay_of(dly_mode)) ref_cts = 1;
      end
      if (at_tick) begin
        if (ref_cd == !cd_fast_n) cd_run = 0;
        else begin
          cd_run++;
          if (cd_run >= (ref_cd ? CDOFF : CDON)) begin ref_cd = !ref_cd; cd_run = 0; end
        end
      end
      if (sq_off) sq_left = 0;
      else if (rts_n && !prev_rts) sq_left = SQT;
      else if (at_tick && sq_left > 0) sq_left--;
      prev_rts = rts_n;
      cyc++;
    end
  end

  function automatic logic e_cts();
    if (loop_test) return rts_n;
    if (dly_mode[1]) return ext_rts_n;
    return !(ref_cts && !rts_n);
  endfunction
  function automatic logic e_cd();
    return dly_mode[1] ? cd_ext_n : !ref_cd;
  endfunction
  function automatic logic e_rx();
    if (loop_test) return tx_data;
    if (e_cd() || (!sq_off && !rts_n) || sq_left > 0) return 1'b1;
    return rx_demod;
  endfunction
  function automatic logic e_car();
    return loop_test ? carrier_ctl : !rts_n;
  endfunction
  function automatic logic e_mod();
    if (!e_car()) return 1'b1;
    return loop_test ? rx_demod : tx_data;
  endfunction

  always @(negedge clk) if (cmp_on) begin
    chk("R1", "timing_clk", timing_clk, (cyc % PER) >= PER / 2);
    chk(loop_test ? "R7" : (dly_mode[1] ? "R3" : "R2"), "cts_n", cts_n, e_cts());
    chk(dly_mode[1] ? "R3" : "R4", "cd_n", cd_n, e_cd());
    chk(loop_test ? "R7" : "R6", "rx_data", rx_data, e_rx());
    chk(loop_test ? "R7" : "R8", "tx_carrier_en", tx_carrier_en, e_car());
    chk("R8", "tx_mod_data", tx_mod_data, e_mod());
    chk("R9", "tone_on", tone_on, !tone_en_n && !rts_n);
  end

  task automatic hold(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R10", "reset cts_n", cts_n, 1'b1);
    chk("R10", "reset cd_n", cd_n, 1'b1);
    chk("R10", "reset timing_clk", timing_clk, 1'b0);
    @(posedge clk); #2; rst_n = 1'b1; cmp_on = 1;

    // R2 long delay
    hold(5); rts_n = 1'b0;
    hold(20); @(negedge clk); chk("R2", "long delay not yet", cts_n, 1'b1);
    hold(50); @(negedge clk); chk("R2", "long delay granted", cts_n, 1'b0);
    rts_n = 1'b1; #1; chk("R2", "cts drops with rts", cts_n, 1'b1);
    // R2 short delay
    hold(3); dly_mode = 2'd1; rts_n = 1'b0;
    hold(30); @(negedge clk); chk("R2", "short delay granted", cts_n, 1'b0);
    hold(1); rts_n = 1'b1;
    // R4 glitch shorter than CD_ON ticks is ignored
    hold(40); cd_fast_n = 1'b0; hold(12); cd_fast_n = 1'b1;
    hold(1); @(negedge clk); chk("R4", "short glitch ignored", cd_n, 1'b1);
    cd_fast_n = 1'b0; hold(40); @(negedge clk); chk("R4", "carrier qualified", cd_n, 1'b0);
    // R5/R6 squelch after transmit
    rx_demod = 1'b0; hold(2); @(negedge clk); chk("R6", "data passes", rx_data, 1'b0);
    hold(1); rts_n = 1'b0; hold(3); @(negedge clk); chk("R6", "two-wire tx forces mark", rx_data, 1'b1);
    hold(1); rts_n = 1'b1; hold(3); @(negedge clk); chk("R5", "squelch holds mark", rx_data, 1'b1);
    hold(60); @(negedge clk); chk("R5", "squelch ended", rx_data, 1'b0);
    // R5 four-wire: no squelch
    sq_off = 1'b1; hold(1); rts_n = 1'b0; hold(3); @(negedge clk); chk("R6", "four-wire tx passes", rx_data, 1'b0);
    hold(1); rts_n = 1'b1; hold(2); @(negedge clk); chk("R5", "no squelch when off", rx_data, 1'b0);
    sq_off = 1'b0;
    // R3 external delays
    hold(1); dly_mode = 2'd2; ext_rts_n = 1'b0; cd_ext_n = 1'b1; #1;
    chk("R3", "external cts", cts_n, 1'b0); chk("R3", "external cd", cd_n, 1'b1);
    // R7 loopback
    hold(1); dly_mode = 2'd0; loop_test = 1'b1; rts_n = 1'b0; carrier_ctl = 1'b0; tx_data = 1'b0; #1;
    chk("R7", "loop cts immediate", cts_n, 1'b0);
    chk("R7", "loop rx from tx", rx_data, 1'b0);
    chk("R7", "loop carrier from cc", tx_carrier_en, 1'b0);
    // R9 answer tone
    hold(1); loop_test = 1'b0; tone_en_n = 1'b0; #1; chk("R9", "tone on", tone_on, 1'b1);
    hold(1); rts_n = 1'b1; #1; chk("R9", "tone needs rts", tone_on, 1'b0);

    // random phase
    for (int s = 0; s < 500; s++) begin
      hold(1 + $urandom_range(39));
      rts_n     = ($urandom_range(2) != 0) ? rts_n : ~rts_n;
      tx_data   = $urandom_range(1);
      rx_demod  = $urandom_range(1);
      if ($urandom_range(3) == 0) cd_fast_n = ~cd_fast_n;
      if ($urandom_range(7) == 0) sq_off = ~sq_off;
      loop_test = ($urandom_range(9) == 0);
      carrier_ctl = $urandom_range(1);
      if ($urandom_range(5) == 0) dly_mode = 2'($urandom_range(3));
      ext_rts_n = $urandom_range(1);
      cd_ext_n  = $urandom_range(1);
      tone_en_n = $urandom_range(1);
    end
    hold(4);
    done = 1;
    finish_run();
  end
endmodule